// File: doc/BRIEF.md
# Multiply Stage with Overflow Control for a Multiply-Accumulate Unit

This block is the product-forming stage in front of a multiply-accumulate unit. It takes two 32-bit operands and an arithmetic mode, and produces a 64-bit product ready for accumulation. The supported modes are signed integer, unsigned integer and fractional. Two control bits come from the unit's status register:
- a saturate-on-overflow bit;
- a round-to-nearest bit.

In the integer modes the stage checks whether the product fits a 40-bit window. When it does not fit, the stage raises a one-cycle overflow pulse. It then either wraps the product into the window or, when saturation is enabled, replaces it with a fixed marker value at bit 50. In fractional mode the stage drops the 24 low bits of the unsigned product, with optional round-half-to-even.

The stage has one cycle of latency. A transfer presented with `in_valid` high at one rising edge appears at the outputs with `out_valid` high after that edge. The overflow output is a set-only pulse. The status register that owns the sticky overflow bit ORs the pulse into that bit; this stage never clears it.

Top module: `mac_mul_stage`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each edge that samples `in_valid` high. A synchronous `rst` drives `out_valid`, `ovf_set` and `product` to zero.
- R2: Mode code 0 (signed) multiplies the operands as two's-complement numbers. With no overflow, the result is the exact product. With overflow and `sat_en` low, the result is the product's low 40 bits sign-extended from bit 39.
- R3: In signed mode, `ovf_set` is raised when the exact product lies outside the signed 40-bit range [-2^39, 2^39-1]. With `sat_en` high, the result is then 2^50 for a non-negative product and the bitwise inverse of 2^50 for a negative one.
- R4: Mode code 1 (unsigned) multiplies the operands as unsigned numbers. `ovf_set` is raised when any of product bits 63..40 is set.
- R5: On unsigned overflow, the result is 2^50 when `sat_en` is high and the product's low 40 bits, zero-extended, when it is low. Without overflow, the result is the exact product.
- R6: Mode code 2 (fractional) with `round_en` low gives the unsigned product shifted right by 24 bits.
- R7: Fractional mode with `round_en` high compares the 24 discarded bits with 0x800000. Above 0x800000 the shifted value rounds up by one. Exactly 0x800000 adds the shifted value's bit 0. Below 0x800000 it truncates.
- R8: Fractional mode never raises `ovf_set`, whatever `sat_en` is. Mode code 3 behaves exactly like mode code 2.
- R9: `ovf_set` is never high while `out_valid` is low. `product` holds its last value through cycles in which `in_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are presented this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| mode | input | 2 | 0 signed, 1 unsigned, 2 or 3 fractional |
| sat_en | input | 1 | Substitute the marker value on integer overflow |
| round_en | input | 1 | Round half to even in fractional mode |
| out_valid | output | 1 | Result registers hold a new product |
| product | output | 64 | Product ready for accumulation |
| ovf_set | output | 1 | One-cycle pulse to OR into the sticky overflow bit |

## Verification
Each internal path has a distinct signature at the ports, and the stage holds only one register level, so any fault shows on `product` or `ovf_set` in the cycle right after the transfer that exposes it:
- A wrong window boundary moves the overflow pulse by one product value. The signed pair -2^31 × 256 and -2^31 × -256 sits on that boundary.
- A swapped sign test on the marker inverts the 64-bit result.
- A rounding fault appears only on exact ties with an odd or even shifted value, or one count away from them.

The directed table places operands on each of these edges. The random sweep then covers the general products.

// File: rtl/mac_mul_pkg.sv
package mac_mul_pkg;

    localparam int OPND_W     = 32;
    localparam int PROD_W     = 2 * OPND_W;
    localparam int WINDOW_W   = 40;
    localparam int MARKER_BIT = 50;
    localparam int FRAC_DROP  = 24;

    typedef enum logic [1:0] {
        MUL_SIGNED   = 2'd0,
        MUL_UNSIGNED = 2'd1,
        MUL_FRACT    = 2'd2,
        MUL_FRACT_B  = 2'd3
    } mul_mode_e;

    typedef struct packed {
        logic [PROD_W-1:0] value;
        logic              ovf;
    } mul_result_t;

    function automatic logic is_fract(input mul_mode_e m);
        return m[1];
    endfunction

endpackage

// File: rtl/mac_mul_array.sv
module mac_mul_array #(
    parameter int OP_W = 32,
    localparam int P_W = 2 * OP_W,
    localparam int X_W = 2 * OP_W + 2
) (
    input  logic            signed_en,
    input  logic [OP_W-1:0] a,
    input  logic [OP_W-1:0] b,
    output logic [P_W-1:0]  prod
);
    logic              a_top;
    logic              b_top;
    logic [X_W-1:0]    a_ext;
    logic [X_W-1:0]    b_ext;
    logic [X_W-1:0]    full;

    always_comb begin
        a_top = signed_en & a[OP_W-1];
        b_top = signed_en & b[OP_W-1];
        a_ext = {{(X_W-OP_W){a_top}}, a};
        b_ext = {{(X_W-OP_W){b_top}}, b};
        full  = a_ext * b_ext;
        prod  = full[P_W-1:0];
    end
endmodule

// File: rtl/mac_mul_window.sv
module mac_mul_window #(
    parameter int P_W     = 64,
    parameter int WIN_W   = 40,
    parameter int MARK_AT = 50,
    localparam int HI_W   = P_W - WIN_W
) (
    input  logic           signed_en,
    input  logic           sat_en,
    input  logic [P_W-1:0] prod,
    output logic [P_W-1:0] value,
    output logic           ovf
);
    localparam logic [P_W-1:0] MARKER = {{(P_W-1){1'b0}}, 1'b1} << MARK_AT;

    logic [HI_W-1:0] upper;
    logic [HI_W-1:0] sign_fill;
    logic [P_W-1:0]  wrapped;
    logic            negative;

    always_comb begin
        upper     = prod[P_W-1:WIN_W];
        sign_fill = {HI_W{signed_en & prod[WIN_W-1]}};
        wrapped   = {sign_fill, prod[WIN_W-1:0]};
        negative  = signed_en & prod[P_W-1];
        ovf       = (upper != sign_fill);
        if (ovf && sat_en) begin
            value = negative ? ~MARKER : MARKER;
        end else begin
            value = wrapped;
        end
    end
endmodule

// File: rtl/mac_mul_fract.sv
module mac_mul_fract #(
    parameter int P_W  = 64,
    parameter int DROP = 24
) (
    input  logic           round_en,
    input  logic [P_W-1:0] prod,
    output logic [P_W-1:0] value
);
    localparam logic [DROP-1:0] HALF = {1'b1, {(DROP-1){1'b0}}};

    logic [P_W-1:0]  kept;
    logic [DROP-1:0] tail;
    logic            bump;

    always_comb begin
        kept  = prod >> DROP;
        tail  = prod[DROP-1:0];
        bump  = round_en & ((tail > HALF) | ((tail == HALF) & kept[0]));
        value = kept + {{(P_W-1){1'b0}}, bump};
    end
endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage
    import mac_mul_pkg::*;
#(
    parameter int OP_W    = OPND_W,
    parameter int WIN_W   = WINDOW_W,
    parameter int MARK_AT = MARKER_BIT,
    parameter int DROP    = FRAC_DROP,
    localparam int P_W    = 2 * OP_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    input  logic [1:0]      mode,
    input  logic            sat_en,
    input  logic            round_en,
    output logic            out_valid,
    output logic [P_W-1:0]  product,
    output logic            ovf_set
);
    mul_mode_e   mode_q;
    logic        signed_en;
    logic        frac_sel;
    logic [P_W-1:0] raw;
    logic [P_W-1:0] int_val;
    logic           int_ovf;
    logic [P_W-1:0] frac_val;
    mul_result_t    nxt;

    always_comb begin
        mode_q    = mul_mode_e'(mode);
        frac_sel  = is_fract(mode_q);
        signed_en = (mode_q == MUL_SIGNED);
    end

    mac_mul_array #(.OP_W(OP_W)) u_array (
        .signed_en (signed_en),
        .a         (op_a),
        .b         (op_b),
        .prod      (raw)
    );

    mac_mul_window #(.P_W(P_W), .WIN_W(WIN_W), .MARK_AT(MARK_AT)) u_window (
        .signed_en (signed_en),
        .sat_en    (sat_en),
        .prod      (raw),
        .value     (int_val),
        .ovf       (int_ovf)
    );

    mac_mul_fract #(.P_W(P_W), .DROP(DROP)) u_fract (
        .round_en (round_en),
        .prod     (raw),
        .value    (frac_val)
    );

    always_comb begin
        if (frac_sel) begin
            nxt.value = frac_val;
            nxt.ovf   = 1'b0;
        end else begin
            nxt.value = int_val;
            nxt.ovf   = int_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            ovf_set   <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            ovf_set   <= in_valid & nxt.ovf;
            if (in_valid) begin
                product <= nxt.value;
            end
        end
    end
endmodule

// File: rtl/mac_mul_stage_chk.sv
module mac_mul_stage_chk #(
    parameter int P_W   = 64,
    parameter int WIN_W = 40
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [1:0]     mode,
    input logic           sat_en,
    input logic           out_valid,
    input logic [P_W-1:0] product,
    input logic           ovf_set
);
    localparam int HI_W = P_W - WIN_W;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_follows_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_signed_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd0 && !sat_en) |=>
        (product[P_W-1:WIN_W] == {HI_W{product[WIN_W-1]}}));

    assert_unsigned_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == 2'd1 && !sat_en) |=>
        (product[P_W-1:WIN_W] == '0));

    assert_no_ovf_fract_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode[1]) |=> !ovf_set);

    assert_pulse_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
        ovf_set |-> out_valid);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(product));
endmodule

bind mac_mul_stage mac_mul_stage_chk #(.P_W(P_W), .WIN_W(WIN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .mode      (mode),
    .sat_en    (sat_en),
    .out_valid (out_valid),
    .product   (product),
    .ovf_set   (ovf_set)
);

// File: tb/tb_mac_mul_stage.sv
module tb_mac_mul_stage;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [1:0]  mode;
    logic        sat_en;
    logic        round_en;
    logic        out_valid;
    logic [63:0] product;
    logic        ovf_set;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    mac_mul_stage dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
        .mode(mode), .sat_en(sat_en), .round_en(round_en),
        .out_valid(out_valid), .product(product), .ovf_set(ovf_set)
    );

    typedef struct packed {
        logic [1:0]  md;
        logic        sat;
        logic        rnd;
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] exp_val;
        logic        exp_ovf;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 32'd3,          32'd5,          64'd15,                  1'b0, 8'd2}, // R2
        '{2'd0, 1'b0, 1'b0, 32'hFFFFFFFF,   32'd7,          64'hFFFFFFFFFFFFFFF9,    1'b0, 8'd2}, // R2
        '{2'd0, 1'b1, 1'b0, 32'h80000000,   32'h80000000,   64'h0004000000000000,    1'b1, 8'd3}, // R3
        '{2'd0, 1'b0, 1'b0, 32'h80000000,   32'h80000000,   64'h0,                   1'b1, 8'd2}, // R2
        '{2'd0, 1'b1, 1'b0, 32'h80000000,   32'h7FFFFFFF,   64'hFFFBFFFFFFFFFFFF,    1'b1, 8'd3}, // R3
        '{2'd0, 1'b0, 1'b0, 32'h80000000,   32'h7FFFFFFF,   64'h0000000080000000,    1'b1, 8'd2}, // R2
        '{2'd0, 1'b1, 1'b0, 32'h80000000,   32'h00000100,   64'hFFFFFF8000000000,    1'b0, 8'd3}, // R3
        '{2'd0, 1'b1, 1'b0, 32'h80000000,   32'hFFFFFF00,   64'h0004000000000000,    1'b1, 8'd3}, // R3
        '{2'd1, 1'b0, 1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   64'h000000FE00000001,    1'b1, 8'd5}, // R5
        '{2'd1, 1'b1, 1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   64'h0004000000000000,    1'b1, 8'd5}, // R5
        '{2'd1, 1'b0, 1'b0, 32'h00010000,   32'h00010000,   64'h0000000100000000,    1'b0, 8'd4}, // R4
        '{2'd1, 1'b1, 1'b0, 32'h00000100,   32'hFFFFFFFF,   64'h000000FFFFFFFF00,    1'b0, 8'd4}, // R4
        '{2'd2, 1'b0, 1'b0, 32'h01000000,   32'd3,          64'd3,                   1'b0, 8'd6}, // R6
        '{2'd2, 1'b0, 1'b0, 32'h01800000,   32'd1,          64'd1,                   1'b0, 8'd6}, // R6
        '{2'd2, 1'b0, 1'b1, 32'h00800000,   32'd1,          64'd0,                   1'b0, 8'd7}, // R7
        '{2'd2, 1'b0, 1'b1, 32'h01800000,   32'd1,          64'd2,                   1'b0, 8'd7}, // R7
        '{2'd2, 1'b0, 1'b1, 32'h00800001,   32'd1,          64'd1,                   1'b0, 8'd7}, // R7
        '{2'd2, 1'b0, 1'b1, 32'h007FFFFF,   32'd1,          64'd0,                   1'b0, 8'd7}, // R7
        '{2'd2, 1'b1, 1'b1, 32'hFFFFFFFF,   32'hFFFFFFFF,   64'h000000FFFFFFFE00,    1'b0, 8'd8}, // R8
        '{2'd3, 1'b1, 1'b1, 32'h01800000,   32'd1,          64'd2,                   1'b0, 8'd8}, // R8
        '{2'd3, 1'b0, 1'b0, 32'hFFFFFFFF,   32'hFFFFFFFF,   64'h000000FFFFFFFE00,    1'b0, 8'd8}  // R8
    };

    function automatic logic [64:0] ref_model(input logic [1:0] md, input logic sat,
                                              input logic rnd, input logic [31:0] a,
                                              input logic [31:0] b);
        logic [63:0] p;
        logic [63:0] q;
        logic [23:0] t;
        logic        ov;
        if (md == 2'd0) begin
            p  = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
            ov = ($signed(p) > 64'sd549755813887) || ($signed(p) < -64'sd549755813888);
            if (ov && sat) q = p[63] ? ~(64'd1 << 50) : (64'd1 << 50);
            else           q = {{24{p[39]}}, p[39:0]};
        end else begin
            p = {32'd0, a} * {32'd0, b};
            if (md == 2'd1) begin
                ov = (p >= (64'd1 << 40));
                if (ov && sat) q = 64'd1 << 50;
                else           q = {24'd0, p[39:0]};
            end else begin
                ov = 1'b0;
                q  = p / 64'd16777216;
                t  = p[23:0];
                if (rnd && (t > 24'h800000 || (t == 24'h800000 && q[0]))) q = q + 64'd1;
            end
        end
        return {ov, q};
    endfunction

    task automatic check(input string what, input int req, input logic [63:0] exp_val,
                         input logic exp_ovf, input logic exp_vld);
        n_cmp++;
        if (product !== exp_val || ovf_set !== exp_ovf || out_valid !== exp_vld) begin
            n_bad++;
            $display("FAIL R%0d %s: got val=%h ovf=%b vld=%b expected val=%h ovf=%b vld=%b",
                     req, what, product, ovf_set, out_valid, exp_val, exp_ovf, exp_vld);
        end
    endtask

    task automatic apply(input logic [1:0] md, input logic sat, input logic rnd,
                         input logic [31:0] a, input logic [31:0] b);
        in_valid = 1'b1; mode = md; sat_en = sat; round_en = rnd; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: got no end of run expected end before cycle limit");
        finish_run();
    end

    initial begin
        logic [64:0] r;
        rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0;
        mode = 2'd0; sat_en = 1'b0; round_en = 1'b0;
        repeat (3) @(negedge clk);
        check("reset state", 1, 64'd0, 1'b0, 1'b0); // R1
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].md, VECS[i].sat, VECS[i].rnd, VECS[i].a, VECS[i].b);
            check($sformatf("vector %0d", i), int'(VECS[i].req),
                  VECS[i].exp_val, VECS[i].exp_ovf, 1'b1);
        end

        // R9: idle cycle after an overflowing transfer holds product, no pulse
        apply(2'd1, 1'b0, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF);
        in_valid = 1'b0; op_a = 32'd1; op_b = 32'd1;
        @(negedge clk);
        check("idle hold", 9, 64'h000000FE00000001, 1'b0, 1'b0);
        @(negedge clk);
        check("idle hold second cycle", 9, 64'h000000FE00000001, 1'b0, 1'b0);

        // R1: reset mid-stream clears outputs
        apply(2'd0, 1'b1, 1'b0, 32'h80000000, 32'h80000000);
        rst = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("reset after traffic", 1, 64'd0, 1'b0, 1'b0);
        rst = 1'b0;

        // Random sweep across all modes (R2 R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 600; i++) begin
            logic [1:0]  md;
            logic        s;
            logic        rn;
            logic [31:0] a;
            logic [31:0] b;
            md = 2'($urandom_range(0, 3));
            s  = 1'($urandom_range(0, 1));
            rn = 1'($urandom_range(0, 1));
            a  = $urandom;
            b  = (i % 3 == 0) ? 32'($urandom_range(0, 1023)) : $urandom;
            r  = ref_model(md, s, rn, a, b);
            apply(md, s, rn, a, b);
            check($sformatf("random mode %0d", md), 2 + int'(md) * 2, r[63:0], r[64], 1'b1);
        end

        in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule